// File: doc/BRIEF.md
# Per-Segment Page Table Entry Fetch Unit

This unit services a translation miss in a scheme where each segment of the address space has its own linear page table. A 32-bit virtual address carries a segment number in its two top bits, an 18-bit virtual page number in bits 29:12 and a 12-bit page offset. The segment number picks one of three register pairs. Each pair holds the physical address of that segment's page table and the number of entries the table holds.

When a miss is presented, the unit checks the page number against the selected entry count. It forms the entry address as table address plus four times the page number. It then issues one read over a valid/ready request port and waits for a single-cycle response. The outcome is reported as a one-cycle completion pulse with a status code and, on success, the fetched entry. An address in the unused segment, or a page past the end of its table, is rejected without any memory traffic.

Software reloads the register pairs through a small write port, for example on a context switch. Writes wait until no miss is in progress.

Top module: `seg_pte_fetch`

## Requirements
- R1: A miss whose address has bits 31:30 equal to 00 completes in the cycle after acceptance with status 1 (segment fault) and issues no memory request.
- R2: A miss whose page number (bits 29:12) is greater than or equal to the selected entry count completes in the cycle after acceptance with status 2 (bounds fault) and issues no memory request; a page number one below the count is translated normally.
- R3: Segment code 01 uses register pair 1, 10 uses pair 2 and 11 uses pair 3, and the requested address is that pair's table address plus the page number times 4, modulo 2^32.
- R4: The memory request stays asserted with an unchanged address until it is accepted, and at most one request is issued per miss.
- R5: A response with bit 31 set ends with status 0 (ok) and the response word as the entry output; a response with bit 31 clear ends with status 3 (invalid page) and an entry output of zero.
- R6: Completion is a single-cycle pulse on done, with status and entry valid in that cycle.
- R7: A register write takes cfg_idx 1 to 3 as the pair, cfg_sel 0 for the table address and 1 for the entry count (low 19 bits of cfg_wdata); a write with cfg_idx 0 changes nothing.
- R8: cfg_ready is low while a miss is in progress, and a write held during that time takes effect only once the unit is idle; miss_ready is low in any cycle where cfg_we is high.
- R9: After reset the unit is idle with done and the memory request low, and all entry counts are zero so every miss in segments 01 to 11 ends in a bounds fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_vaddr | input | 32 | Virtual address of the miss |
| miss_ready | output | 1 | Unit accepts a miss this cycle |
| cfg_we | input | 1 | Register write request |
| cfg_idx | input | 2 | Register pair index (1 to 3) |
| cfg_sel | input | 1 | 0 writes table address, 1 writes entry count |
| cfg_wdata | input | 32 | Write data |
| cfg_ready | output | 1 | Write is applied this cycle when cfg_we is high |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Physical address of the page table entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 segment fault, 2 bounds fault, 3 invalid page |
| pte | output | 32 | Fetched entry on ok, zero otherwise |

## Verification
A wrong segment decode or a corrupted register pair shows at the request port on the first translated miss, as a wrong entry address or as a fault where a request was due. A faulty bounds comparison shows in the cycle after acceptance, as a done pulse with the wrong status or as a stray request. A controller stuck out of idle shows as cfg_ready and miss_ready staying low and done never rising. A write that slips through while busy shows on the next miss that uses the changed pair.

// File: rtl/seg_pte_pkg.sv
package seg_pte_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_SEG     = 2'd1,
    ST_BOUNDS  = 2'd2,
    ST_INVALID = 2'd3
  } walk_status_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_REQ,
    PH_WAIT,
    PH_RESP
  } walk_phase_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 2,
  parameter int BND_W  = 19,
  localparam int NENT  = 1 << SEG_W,
  localparam int ENT_W = ADDR_W + BND_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEG_W-1:0]      wr_idx,
  input  logic                  wr_sel,
  input  logic [ADDR_W-1:0]     wr_data,
  input  logic [SEG_W-1:0]      rd_idx,
  output logic [ADDR_W-1:0]     rd_base,
  output logic [BND_W-1:0]      rd_bound,
  output logic [NENT*ENT_W-1:0] all_flat
);
  logic [ADDR_W-1:0] base_q  [NENT];
  logic [BND_W-1:0]  bound_q [NENT];

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    if (g == 0) begin : g_unused
      assign base_q[g]  = '0;
      assign bound_q[g] = '0;
    end else begin : g_pair
      logic hit;
      assign hit = wr_en && (wr_idx == SEG_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          base_q[g]  <= '0;
          bound_q[g] <= '0;
        end else begin
          if (hit && !wr_sel) base_q[g]  <= wr_data;
          if (hit && wr_sel)  bound_q[g] <= wr_data[BND_W-1:0];
        end
      end
    end
    assign all_flat[g*ENT_W +: ENT_W] = {base_q[g], bound_q[g]};
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_bound = bound_q[rd_idx];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 2,
  parameter int VPN_W  = 18,
  parameter int ENT_LG = 2,
  localparam int BND_W = VPN_W + 1,
  localparam int PAD_W = ADDR_W - VPN_W - ENT_LG
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ADDR_W-1:0] base,
  input  logic [BND_W-1:0]  bound,
  output logic              seg_zero,
  output logic              over_bound,
  output logic [ADDR_W-1:0] pte_addr
);
  assign seg_zero   = (seg == '0);
  assign over_bound = ({1'b0, vpn} >= bound);
  assign pte_addr   = base + {{PAD_W{1'b0}}, vpn, {ENT_LG{1'b0}}};
endmodule

// File: rtl/seg_walk_fsm.sv
module seg_walk_fsm
  import seg_pte_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seg_zero,
  input  logic              over_bound,
  input  logic [ADDR_W-1:0] pte_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              idle,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              done,
  output logic [1:0]        status,
  output logic [DATA_W-1:0] pte
);
  walk_phase_e  ph_q, ph_d;
  walk_status_e st_q, st_d;
  logic [DATA_W-1:0] pte_q, pte_d;
  logic [ADDR_W-1:0] addr_q;
  logic addr_en, res_en;

  always_comb begin
    ph_d    = ph_q;
    st_d    = st_q;
    pte_d   = pte_q;
    addr_en = 1'b0;
    res_en  = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        res_en = 1'b1;
        pte_d  = '0;
        if (seg_zero) begin
          st_d = ST_SEG;
          ph_d = PH_RESP;
        end else if (over_bound) begin
          st_d = ST_BOUNDS;
          ph_d = PH_RESP;
        end else begin
          st_d    = ST_OK;
          addr_en = 1'b1;
          ph_d    = PH_REQ;
        end
      end
      PH_REQ:  if (mem_req_ready) ph_d = PH_WAIT;
      PH_WAIT: if (mem_rsp_valid) begin
        res_en = 1'b1;
        if (mem_rsp_data[DATA_W-1]) begin
          st_d  = ST_OK;
          pte_d = mem_rsp_data;
        end else begin
          st_d  = ST_INVALID;
          pte_d = '0;
        end
        ph_d = PH_RESP;
      end
      PH_RESP: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      st_q   <= ST_OK;
      pte_q  <= '0;
      addr_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (res_en) begin
        st_q  <= st_d;
        pte_q <= pte_d;
      end
      if (addr_en) addr_q <= pte_addr;
    end
  end

  assign idle          = (ph_q == PH_IDLE);
  assign mem_req_valid = (ph_q == PH_REQ);
  assign mem_req_addr  = addr_q;
  assign done          = (ph_q == PH_RESP);
  assign status        = st_q;
  assign pte           = pte_q;
endmodule

// File: rtl/seg_pte_fetch.sv
module seg_pte_fetch #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 2,
  parameter int OFF_W  = 12,
  parameter int ENT_LG = 2,
  localparam int VPN_W = ADDR_W - SEG_W - OFF_W,
  localparam int BND_W = VPN_W + 1,
  localparam int NENT  = 1 << SEG_W,
  localparam int FLAT_W = NENT * (ADDR_W + BND_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_vaddr,
  output logic              miss_ready,
  input  logic              cfg_we,
  input  logic [SEG_W-1:0]  cfg_idx,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              cfg_ready,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] pte
);
  logic [SEG_W-1:0]  seg;
  logic [VPN_W-1:0]  vpn;
  logic [ADDR_W-1:0] sel_base;
  logic [BND_W-1:0]  sel_bound;
  logic [ADDR_W-1:0] pte_addr;
  logic [FLAT_W-1:0] reg_flat;
  logic seg_zero, over_bound, idle, start, wr_en;

  assign seg        = miss_vaddr[ADDR_W-1 -: SEG_W];
  assign vpn        = miss_vaddr[OFF_W +: VPN_W];
  assign cfg_ready  = idle;
  assign wr_en      = cfg_we && idle;
  assign miss_ready = idle && !cfg_we;
  assign start      = miss_valid && miss_ready;

  seg_regfile #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .BND_W(BND_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(cfg_idx),
    .wr_sel(cfg_sel), .wr_data(cfg_wdata), .rd_idx(seg),
    .rd_base(sel_base), .rd_bound(sel_bound), .all_flat(reg_flat)
  );

  seg_addr_gen #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .VPN_W(VPN_W),
                 .ENT_LG(ENT_LG)) u_agen (
    .seg(seg), .vpn(vpn), .base(sel_base), .bound(sel_bound),
    .seg_zero(seg_zero), .over_bound(over_bound), .pte_addr(pte_addr)
  );

  seg_walk_fsm #(.ADDR_W(ADDR_W), .DATA_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_zero(seg_zero),
    .over_bound(over_bound), .pte_addr(pte_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .idle(idle),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .done(done), .status(status), .pte(pte)
  );
endmodule

// File: rtl/seg_pte_fetch_chk.sv
module seg_pte_fetch_chk #(
  parameter int ADDR_W = 32,
  parameter int FLAT_W = 204
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_valid,
  input logic [ADDR_W-1:0] miss_vaddr,
  input logic              miss_ready,
  input logic              cfg_we,
  input logic              cfg_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              done,
  input logic [1:0]        status,
  input logic [ADDR_W-1:0] pte,
  input logic [FLAT_W-1:0] reg_flat
);
  a_r1_vaddr_known: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |-> !$isunknown(miss_vaddr));
  a_r1_seg_zero_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready && miss_vaddr[ADDR_W-1 -: 2] == 2'b00)
    |=> (done && status == 2'd1 && !mem_req_valid));
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r4_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cfg_ready);
  a_r5_ok_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd0) |-> pte[ADDR_W-1]);
  a_r5_fault_zero_pte: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status != 2'd0) |-> (pte == '0));
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cfg_ready);
  a_r8_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_ready) |=> $stable(reg_flat));
  a_r8_miss_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !miss_ready);
endmodule

bind seg_pte_fetch seg_pte_fetch_chk #(.ADDR_W(ADDR_W), .FLAT_W(FLAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
  .miss_ready(miss_ready), .cfg_we(cfg_we), .cfg_ready(cfg_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .status(status), .pte(pte),
  .reg_flat(reg_flat)
);

// File: tb/seg_pte_fetch_bench.sv
`timescale 1ns/1ps
module seg_pte_fetch_bench;
  localparam logic [1:0] S_OK = 2'd0, S_SEG = 2'd1, S_BND = 2'd2, S_INV = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic miss_ready;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic cfg_ready;
  logic mem_req_valid;
  logic [31:0] mem_req_addr;
  logic mem_req_ready = 1'b0;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic done;
  logic [1:0] status;
  logic [31:0] pte;

  int checks = 0;
  int errors = 0;
  int stall = 0;
  int req_count = 0;
  logic [31:0] seen_addr = '0;
  logic [31:0] rsp_word = '0;

  always #2.5 clk = ~clk;

  seg_pte_fetch u_seg_pte_fetch (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_ready(miss_ready), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .status(status), .pte(pte)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: optional stall, accept, response two edges later
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] first_addr;
        first_addr = mem_req_addr;
        for (int i = 0; i < stall; i++) begin
          @(negedge clk);
          check(mem_req_valid && mem_req_addr == first_addr, "R4 request held",
                mem_req_addr, first_addr);
        end
        mem_req_ready = 1'b1;
        seen_addr = mem_req_addr;
        req_count++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(!mem_req_valid, "R4 single request", {31'd0, mem_req_valid}, 32'd0);
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rsp_word;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] idx, input logic sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_sel = sel; cfg_wdata = d;
    while (!cfg_ready) @(negedge clk);
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  task automatic do_miss(input logic [31:0] va, output logic [1:0] st,
                         output logic [31:0] p, output int cyc);
    @(negedge clk);
    miss_valid = 1'b1; miss_vaddr = va;
    while (!miss_ready) @(negedge clk);
    @(posedge clk);
    #1 miss_valid = 1'b0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!done && cyc < 100);
    st = status; p = pte;
    @(negedge clk);
    check(!done, "R6 done is one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset();
    logic [1:0] st; logic [31:0] p; int cyc; int rc;
    check(!done && !mem_req_valid && cfg_ready && miss_ready, "R9 idle after reset",
          {28'd0, done, mem_req_valid, cfg_ready, miss_ready}, 32'h3);
    rc = req_count;
    do_miss(32'h4000_0000, st, p, cyc);
    check(st == S_BND && cyc == 1, "R9 zero count gives bounds fault", {30'd0, st}, S_BND);
    check(req_count == rc, "R9 no request", req_count, rc);
  endtask

  task automatic t_setup();
    cfg_write(2'd1, 1'b0, 32'h0010_0000);
    cfg_write(2'd1, 1'b1, 32'd3);
    cfg_write(2'd2, 1'b0, 32'h0020_0000);
    cfg_write(2'd2, 1'b1, 32'd64);
    cfg_write(2'd3, 1'b0, 32'h0030_0000);
    cfg_write(2'd3, 1'b1, 32'h0004_0000);
    cfg_write(2'd0, 1'b0, 32'hDEAD_0000); // R7 index 0 must be ignored
    cfg_write(2'd0, 1'b1, 32'h0000_0100);
  endtask

  task automatic t_seg_zero();
    logic [1:0] st; logic [31:0] p; int cyc; int rc;
    rc = req_count;
    do_miss(32'h0000_1abc, st, p, cyc);
    check(st == S_SEG, "R1 segment fault status", {30'd0, st}, S_SEG);
    check(cyc == 1, "R1 fault one cycle after accept", cyc, 1);
    check(req_count == rc && p == 0, "R1 no request, zero entry", req_count, rc);
    check(st != S_OK, "R7 index 0 write left segment 00 unmapped", {30'd0, st}, S_SEG);
  endtask

  task automatic t_code();
    logic [1:0] st; logic [31:0] p; int cyc; int rc;
    stall = 0; rsp_word = 32'h8000_1234;
    do_miss(32'h4000_2abc, st, p, cyc);
    check(seen_addr == 32'h0010_0008, "R3 code entry address", seen_addr, 32'h0010_0008);
    check(st == S_OK && p == 32'h8000_1234, "R5 ok returns entry", p, 32'h8000_1234);
    check(st == S_OK, "R2 last page in bounds", {30'd0, st}, S_OK);
    rc = req_count;
    do_miss(32'h4000_3000, st, p, cyc);
    check(st == S_BND && cyc == 1, "R2 page equal to count faults", {30'd0, st}, S_BND);
    check(req_count == rc, "R2 no request on bounds fault", req_count, rc);
  endtask

  task automatic t_heap_invalid();
    logic [1:0] st; logic [31:0] p; int cyc;
    stall = 4; rsp_word = 32'h0000_5555;
    do_miss(32'h8003_F000, st, p, cyc);
    check(seen_addr == 32'h0020_00FC, "R3 heap entry address", seen_addr, 32'h0020_00FC);
    check(st == S_INV && p == 0, "R5 clear valid bit gives invalid fault", p, 32'h0);
    stall = 0;
  endtask

  task automatic t_stack_top();
    logic [1:0] st; logic [31:0] p; int cyc;
    rsp_word = 32'hC000_0077;
    do_miss(32'hFFFF_F123, st, p, cyc);
    check(seen_addr == 32'h003F_FFFC, "R3 stack top entry address", seen_addr, 32'h003F_FFFC);
    check(st == S_OK && p == 32'hC000_0077, "R2 full-size count accepts top page", p,
          32'hC000_0077);
  endtask

  task automatic t_write_held();
    logic [1:0] st; logic [31:0] p; int cyc;
    stall = 8; rsp_word = 32'h8000_0042;
    fork
      do_miss(32'h4000_1000, st, p, cyc);
      begin
        repeat (3) @(negedge clk);
        check(!cfg_ready, "R8 cfg_ready low while busy", {31'd0, cfg_ready}, 32'd0);
        cfg_write(2'd1, 1'b1, 32'd1);
      end
    join
    check(st == S_OK && seen_addr == 32'h0010_0004, "R8 busy lookup unaffected",
          seen_addr, 32'h0010_0004);
    stall = 0;
    do_miss(32'h4000_1000, st, p, cyc);
    check(st == S_BND, "R8 held write applied after idle", {30'd0, st}, S_BND);
    rsp_word = 32'h8000_0001;
    do_miss(32'h4000_0000, st, p, cyc);
    check(st == S_OK && seen_addr == 32'h0010_0000, "R7 base kept by count write",
          seen_addr, 32'h0010_0000);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd0; cfg_sel = 1'b0;
    #0;
    check(!miss_ready, "R8 miss_ready low under cfg_we", {31'd0, miss_ready}, 32'd0);
    @(posedge clk);
    #1 cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup();
    t_seg_zero();
    t_code();
    t_heap_invalid();
    t_stack_top();
    t_write_held();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule